// File: doc/BRIEF.md
# Single-Slope PWM Timer with Selectable Ceiling

This block is a 16-bit up-counter that generates edge-aligned (single-slope) PWM on two compare channels. An external prescaler supplies a one-cycle `tick` enable, and the counter advances once per tick. The counter climbs to a ceiling and then falls back to zero. The ceiling is set by the 4-bit mode field. It can be one of three fixed values (8, 9 or 10 bits wide), the value of a capture register, or the value of the channel-A compare register.

Software writes the compare, capture and control values through simple strobed write ports. Compare and capture writes go into shadow registers. These are copied into the active registers only on the tick where the counter wraps, so a PWM period never mixes old and new settings. Each channel pin can be configured as non-inverted PWM, inverted PWM, or disconnected. Four sticky event flags record wrap, the two compare matches and the capture-ceiling wrap. Software clears a flag by writing a 1 to its bit.

Top module: `fpwm_timer`

## Requirements
- R1: While `rst_n` is low, `count` is 0, all `flags` bits are 0, `pwm_a` and `pwm_b` are 0, and the mode field is 0.
- R2: A `wr_ctrl` strobe loads `ctrl_data[3:0]` as the mode. The mode sets the ceiling as follows:
  - 5 gives 0x00FF, 6 gives 0x01FF and 7 gives 0x03FF.
  - 14 gives the active capture value and 15 gives the active channel-A compare value.
  - Any other mode gives 0xFFFF.
- R3: On a clock edge with `tick` high, `count` increments by one, or goes to 0 if it equals the ceiling. With `tick` low, `count` holds.
- R4: `flags[0]` (wrap flag) becomes 1 after the tick edge at which `count` equals the ceiling. This is the same edge at which `count` returns to 0.
- R5: `flags[1]` (channel A) and `flags[2]` (channel B) become 1 after a tick edge at which `count` equals that channel's active compare value. A compare value above the ceiling never sets its flag.
- R6: `flags[3]` (capture flag) is set only in mode 14, by the wrap tick. In mode 15 the wrap tick also sets `flags[1]`.
- R7: Compare and capture writes go to shadow registers. A shadow value is copied into the active register on the wrap tick and is used from the cycle after that tick.
- R8: In modes 5, 6 and 7, a compare write keeps only the low 8, 9 or 10 bits of `wr_data`. The mask follows the mode in force at the time of the write. Capture writes are never masked.
- R9: `ctrl_data[5:4]` sets the output for channel A and `ctrl_data[7:6]` sets it for channel B:
  - Setting 2 (non-inverted): the pin goes high after a wrap tick and low after a match tick. If both happen on the same tick, the wrap wins.
  - Setting 3 (inverted): the pin is the complement of the setting-2 level.
  - Settings 0 and 1: the pin drives 0.
- R10: A 1 in `clr_flags[i]` clears `flags[i]` at the next edge. If a set event for the same flag arrives on that edge, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_ctrl | input | 1 | Write strobe for mode and output settings |
| ctrl_data | input | 8 | [3:0] mode, [5:4] channel A output setting, [7:6] channel B output setting |
| wr_cmp_a | input | 1 | Write strobe for the channel A compare shadow |
| wr_cmp_b | input | 1 | Write strobe for the channel B compare shadow |
| wr_cap | input | 1 | Write strobe for the capture shadow |
| wr_data | input | 16 | Data for compare and capture writes |
| clr_flags | input | 4 | Write-1-to-clear for each flag |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | Channel A PWM pin |
| pwm_b | output | 1 | Channel B PWM pin |
| flags | output | 4 | [0] wrap, [1] compare A, [2] compare B, [3] capture-ceiling wrap |

## Verification
Each of the following appears one clock after the edge that caused it:
- the counter value,
- each flag,
- each PWM level.

A new compare or capture value has an effect only from the cycle after the next wrap tick. The bench drives inputs on the falling edge and advances its reference model once per rising edge. It compares every output on the following falling edge, so each comparison sees exactly one registered step. Directed checks place stimulus at known counter values, such as the ceiling, a match position, or a mid-period shadow write. They then sample in the cycle where the requirement says the effect becomes visible, or in the cycle where it must not yet be visible.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;

  localparam int MODE_W    = 4;
  localparam int OSEL_W    = 2;
  localparam int CTRL_W    = MODE_W + 2 * OSEL_W;
  localparam int NUM_FLAGS = 4;

  localparam int FLAG_OVF  = 0;
  localparam int FLAG_CMPA = 1;
  localparam int FLAG_CMPB = 2;
  localparam int FLAG_CAP  = 3;

  // Mode values whose ceiling is special; everything else free-runs.
  typedef enum logic [MODE_W-1:0] {
    TOPM_FIX8  = 4'd5,
    TOPM_FIX9  = 4'd6,
    TOPM_FIX10 = 4'd7,
    TOPM_CAP   = 4'd14,
    TOPM_CMPA  = 4'd15
  } top_mode_e;

  typedef enum logic [OSEL_W-1:0] {
    OUT_OFF0 = 2'd0,
    OUT_OFF1 = 2'd1,
    OUT_NORM = 2'd2,
    OUT_INV  = 2'd3
  } out_mode_e;

endpackage

// File: rtl/fpwm_counter.sv
module fpwm_counter
  import fpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  input  logic [CNT_W-1:0]  cap_top,
  input  logic [CNT_W-1:0]  cmpa_top,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  top_val,
  output logic              wrap
);

  localparam logic [CNT_W-1:0] TOP8    = CNT_W'(32'h0000_00FF);
  localparam logic [CNT_W-1:0] TOP9    = CNT_W'(32'h0000_01FF);
  localparam logic [CNT_W-1:0] TOP10   = CNT_W'(32'h0000_03FF);
  localparam logic [CNT_W-1:0] TOPFREE = '1;

  // Ceiling chosen by the mode field.
  function automatic logic [CNT_W-1:0] pick_top(
    input logic [MODE_W-1:0] m,
    input logic [CNT_W-1:0]  cap_v,
    input logic [CNT_W-1:0]  cmpa_v
  );
    logic [CNT_W-1:0] t;
    case (m)
      TOPM_FIX8:  t = TOP8;
      TOPM_FIX9:  t = TOP9;
      TOPM_FIX10: t = TOP10;
      TOPM_CAP:   t = cap_v;
      TOPM_CMPA:  t = cmpa_v;
      default:    t = TOPFREE;
    endcase
    return t;
  endfunction

  assign top_val = pick_top(mode, cap_top, cmpa_top);
  assign wrap    = tick && (count == top_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (tick) begin
      count <= wrap ? '0 : count + 1'b1;
    end
  end

endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel
  import fpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wrap,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_val,
  input  logic [CNT_W-1:0]  count,
  input  logic [OSEL_W-1:0] out_sel,
  output logic [CNT_W-1:0]  cmp_act,
  output logic              match,
  output logic              pin
);

  logic [CNT_W-1:0] cmp_shadow;
  logic             level;

  // Pin polarity from the channel's output setting.
  function automatic logic drive_pin(input logic [OSEL_W-1:0] sel, input logic lvl);
    logic p;
    case (sel)
      OUT_NORM: p = lvl;
      OUT_INV:  p = !lvl;
      default:  p = 1'b0;
    endcase
    return p;
  endfunction

  assign match = tick && (count == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_shadow <= '0;
      cmp_act    <= '0;
    end else begin
      if (wr_en) cmp_shadow <= wr_val;
      if (wrap)  cmp_act    <= cmp_shadow;
    end
  end

  // Non-inverted level: wrap sets, match clears, wrap has priority.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
    end else if (wrap) begin
      level <= 1'b1;
    end else if (match) begin
      level <= 1'b0;
    end
  end

  assign pin = drive_pin(out_sel, level);

endmodule

// File: rtl/fpwm_flags.sv
module fpwm_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags
);

  // Sticky bits; a set in the same cycle overrides the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= (flags & ~clr_req) | set_ev;
    end
  end

endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer
  import fpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 wr_ctrl,
  input  logic [CTRL_W-1:0]    ctrl_data,
  input  logic                 wr_cmp_a,
  input  logic                 wr_cmp_b,
  input  logic                 wr_cap,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic [NUM_FLAGS-1:0] clr_flags,
  output logic [CNT_W-1:0]     count,
  output logic                 pwm_a,
  output logic                 pwm_b,
  output logic [NUM_FLAGS-1:0] flags
);

  localparam int NCH = 2;

  logic [MODE_W-1:0]    mode_q;
  logic [OSEL_W-1:0]    osel_q [NCH];
  logic [OSEL_W-1:0]    osel_a;
  logic [CNT_W-1:0]     cap_shadow;
  logic [CNT_W-1:0]     cap_act;
  logic [CNT_W-1:0]     top_val;
  logic                 wrap;
  logic [CNT_W-1:0]     cmp_act [NCH];
  logic [NCH-1:0]       match;
  logic [NCH-1:0]       pin;
  logic [NCH-1:0]       wr_ch;
  logic [CNT_W-1:0]     wr_masked;
  logic [NUM_FLAGS-1:0] flag_set;

  // Compare write data trimmed to the fixed resolution of the mode.
  function automatic logic [CNT_W-1:0] mask_for_mode(
    input logic [MODE_W-1:0] m,
    input logic [CNT_W-1:0]  v
  );
    logic [CNT_W-1:0] keep;
    case (m)
      TOPM_FIX8:  keep = CNT_W'(32'h0000_00FF);
      TOPM_FIX9:  keep = CNT_W'(32'h0000_01FF);
      TOPM_FIX10: keep = CNT_W'(32'h0000_03FF);
      default:    keep = '1;
    endcase
    return v & keep;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      for (int i = 0; i < NCH; i++) osel_q[i] <= '0;
    end else if (wr_ctrl) begin
      mode_q <= ctrl_data[MODE_W-1:0];
      for (int i = 0; i < NCH; i++) osel_q[i] <= ctrl_data[MODE_W + i*OSEL_W +: OSEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_shadow <= '0;
      cap_act    <= '0;
    end else begin
      if (wr_cap) cap_shadow <= wr_data;
      if (wrap)   cap_act    <= cap_shadow;
    end
  end

  assign osel_a    = osel_q[0];
  assign wr_ch     = {wr_cmp_b, wr_cmp_a};
  assign wr_masked = mask_for_mode(mode_q, wr_data);

  fpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode     (mode_q),
    .cap_top  (cap_act),
    .cmpa_top (cmp_act[0]),
    .count    (count),
    .top_val  (top_val),
    .wrap     (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    fpwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .wrap    (wrap),
      .wr_en   (wr_ch[g]),
      .wr_val  (wr_masked),
      .count   (count),
      .out_sel (osel_q[g]),
      .cmp_act (cmp_act[g]),
      .match   (match[g]),
      .pin     (pin[g])
    );
  end

  assign pwm_a = pin[0];
  assign pwm_b = pin[1];

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_OVF]  = wrap;
    flag_set[FLAG_CMPA] = match[0] | (wrap && (mode_q == TOPM_CMPA));
    flag_set[FLAG_CMPB] = match[1];
    flag_set[FLAG_CAP]  = wrap && (mode_q == TOPM_CAP);
  end

  fpwm_flags #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (flag_set),
    .clr_req (clr_flags),
    .flags   (flags)
  );

endmodule

// File: rtl/fpwm_checker.sv
module fpwm_checker
  import fpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 wr_ctrl,
  input logic [NUM_FLAGS-1:0] clr_flags,
  input logic [CNT_W-1:0]     count,
  input logic [CNT_W-1:0]     top_val,
  input logic                 wrap,
  input logic [MODE_W-1:0]    mode,
  input logic [OSEL_W-1:0]    osel_a,
  input logic [NUM_FLAGS-1:0] flags,
  input logic                 pwm_a
);

  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count == top_val) |=> (count == '0));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count != top_val) |=> (count == $past(count) + 1'b1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flags[FLAG_OVF]);

  p_cap_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode == 4'd14) |=> flags[FLAG_CAP]);

  p_cap_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLAG_CAP]) |-> $past(wrap && mode == 4'd14));

  p_cmpa_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && mode == 4'd15) |=> flags[FLAG_CMPA]);

  p_norm_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && osel_a == 2'd2 && !wr_ctrl) |=> pwm_a);

  p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (osel_a[1] == 1'b0) |-> !pwm_a);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLAG_OVF] && clr_flags[FLAG_OVF] && !wrap) |=> !flags[FLAG_OVF]);

endmodule

bind fpwm_timer fpwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .wr_ctrl   (wr_ctrl),
  .clr_flags (clr_flags),
  .count     (count),
  .top_val   (top_val),
  .wrap      (wrap),
  .mode      (mode_q),
  .osel_a    (osel_a),
  .flags     (flags),
  .pwm_a     (pwm_a)
);

// File: tb/tb_fpwm_timer.sv
module tb_fpwm_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic        wr_ctrl;
  logic [7:0]  ctrl_data;
  logic        wr_cmp_a;
  logic        wr_cmp_b;
  logic        wr_cap;
  logic [15:0] wr_data;
  logic [3:0]  clr_flags;
  logic [15:0] count;
  logic        pwm_a;
  logic        pwm_b;
  logic [3:0]  flags;

  int n_chk  = 0;
  int n_fail = 0;

  // Reference state
  logic [3:0]  m_mode;
  logic [1:0]  m_osa, m_osb;
  logic [15:0] m_cnt;
  logic [15:0] m_cbuf [2];
  logic [15:0] m_cact [2];
  logic [15:0] m_capb, m_capa;
  logic [1:0]  m_lvl;
  logic [3:0]  m_flg;

  fpwm_timer dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_ctrl(wr_ctrl), .ctrl_data(ctrl_data),
    .wr_cmp_a(wr_cmp_a), .wr_cmp_b(wr_cmp_b), .wr_cap(wr_cap), .wr_data(wr_data),
    .clr_flags(clr_flags), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .flags(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_top(input logic [3:0] m, input logic [15:0] cap, input logic [15:0] ca);
    if (m == 4'd5)  return 16'h00FF;
    if (m == 4'd6)  return 16'h01FF;
    if (m == 4'd7)  return 16'h03FF;
    if (m == 4'd14) return cap;
    if (m == 4'd15) return ca;
    return 16'hFFFF;
  endfunction

  function automatic logic [15:0] exp_mask(input logic [3:0] m, input logic [15:0] v);
    case (m)
      4'd5:    return {8'h00, v[7:0]};
      4'd6:    return {7'h00, v[8:0]};
      4'd7:    return {6'h00, v[9:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic exp_pin(input logic [1:0] sel, input logic lvl);
    if (sel == 2'd2) return lvl;
    if (sel == 2'd3) return ~lvl;
    return 1'b0;
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    logic [15:0] top;
    logic        wrp;
    logic [1:0]  mt;
    logic [3:0]  st;
    top = exp_top(m_mode, m_capa, m_cact[0]);
    wrp = tick && (m_cnt == top);
    for (int i = 0; i < 2; i++) mt[i] = tick && (m_cnt == m_cact[i]);
    st = {wrp && (m_mode == 4'd14), mt[1], mt[0] | (wrp && (m_mode == 4'd15)), wrp};
    m_flg = (m_flg & ~clr_flags) | st;
    for (int i = 0; i < 2; i++) begin
      if (wrp) m_lvl[i] = 1'b1;
      else if (mt[i]) m_lvl[i] = 1'b0;
    end
    if (tick) m_cnt = wrp ? 16'h0 : m_cnt + 16'h1;
    if (wrp) begin
      m_cact[0] = m_cbuf[0];
      m_cact[1] = m_cbuf[1];
      m_capa    = m_capb;
    end
    if (wr_cmp_a) m_cbuf[0] = exp_mask(m_mode, wr_data);
    if (wr_cmp_b) m_cbuf[1] = exp_mask(m_mode, wr_data);
    if (wr_cap)   m_capb    = wr_data;
    if (wr_ctrl) begin
      m_mode = ctrl_data[3:0];
      m_osa  = ctrl_data[5:4];
      m_osb  = ctrl_data[7:6];
    end
  endtask

  task automatic compare_all();
    chk("R3", "count", 32'(count), 32'(m_cnt));
    chk("R4", "wrap flag", 32'(flags[0]), 32'(m_flg[0]));
    chk("R5", "compare A flag", 32'(flags[1]), 32'(m_flg[1]));
    chk("R5", "compare B flag", 32'(flags[2]), 32'(m_flg[2]));
    chk("R6", "capture flag", 32'(flags[3]), 32'(m_flg[3]));
    chk("R9", "pwm_a", 32'(pwm_a), 32'(exp_pin(m_osa, m_lvl[0])));
    chk("R9", "pwm_b", 32'(pwm_b), 32'(exp_pin(m_osb, m_lvl[1])));
  endtask

  // One clock: model advances with the driven inputs, then outputs are compared.
  task automatic cyc();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    wr_ctrl = 1'b0; wr_cmp_a = 1'b0; wr_cmp_b = 1'b0; wr_cap = 1'b0; clr_flags = 4'h0;
    compare_all();
  endtask

  task automatic run_to(input logic [15:0] target);
    int guard = 0;
    while (m_cnt != target && guard < 70000) begin
      tick = 1'b1;
      cyc();
      guard++;
    end
  endtask

  task automatic write_ctrl(input logic [3:0] m, input logic [1:0] oa, input logic [1:0] ob);
    tick = 1'b0; wr_ctrl = 1'b1; ctrl_data = {ob, oa, m};
    cyc();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %0d cycles expected fewer than %0d", WATCHDOG, WATCHDOG);
    summary();
    $finish;
  end

  initial begin
    logic [3:0] modes [5];
    modes = '{4'd5, 4'd6, 4'd7, 4'd14, 4'd15};
    void'($urandom(32'd24681));
    rst_n = 1'b0; tick = 1'b0; wr_ctrl = 1'b0; ctrl_data = 8'h00;
    wr_cmp_a = 1'b0; wr_cmp_b = 1'b0; wr_cap = 1'b0; wr_data = 16'h0; clr_flags = 4'h0;
    m_mode = 4'h0; m_osa = 2'd0; m_osb = 2'd0; m_cnt = 16'h0;
    m_cbuf[0] = 16'h0; m_cbuf[1] = 16'h0; m_cact[0] = 16'h0; m_cact[1] = 16'h0;
    m_capb = 16'h0; m_capa = 16'h0; m_lvl = 2'b00; m_flg = 4'h0;

    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "count in reset", 32'(count), 32'h0);
    chk("R1", "flags in reset", 32'(flags), 32'h0);
    chk("R1", "pins in reset", 32'({pwm_a, pwm_b}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Mode 5, A non-inverted, B inverted
    write_ctrl(4'd5, 2'd2, 2'd3);
    chk("R9", "inverted B idle level", 32'(pwm_b), 32'h1);
    tick = 1'b0; wr_cmp_a = 1'b1; wr_data = 16'h0150; cyc();
    tick = 1'b0; wr_cmp_b = 1'b1; wr_data = 16'h0020; cyc();

    run_to(16'h00FF);
    chk("R2", "8-bit ceiling reached", 32'(count), 32'h00FF);
    tick = 1'b1; cyc();
    chk("R4", "count after ceiling", 32'(count), 32'h0);
    chk("R4", "wrap flag at ceiling", 32'(flags[0]), 32'h1);

    tick = 1'b0; clr_flags = 4'hF; cyc();
    chk("R10", "all flags cleared", 32'(flags), 32'h0);

    run_to(16'h0050);
    tick = 1'b1; cyc();
    chk("R8", "masked compare A matched at 0x50", 32'(flags[1]), 32'h1);
    chk("R9", "non-inverted A low after match", 32'(pwm_a), 32'h0);

    // R7: shadow write mid-period does not alter the running period
    tick = 1'b1; wr_cmp_b = 1'b1; wr_data = 16'h0080; clr_flags = 4'b0100; cyc();
    run_to(16'h0081);
    chk("R7", "new B compare not yet active", 32'(flags[2]), 32'h0);
    run_to(16'h00FF);
    tick = 1'b1; cyc();
    run_to(16'h0080);
    tick = 1'b1; cyc();
    chk("R7", "new B compare active after wrap", 32'(flags[2]), 32'h1);

    // R10: set wins over clear in the same cycle
    run_to(16'h00FF);
    tick = 1'b1; clr_flags = 4'b0001; cyc();
    chk("R10", "set beats clear", 32'(flags[0]), 32'h1);
    tick = 1'b0; clr_flags = 4'b0001; cyc();
    chk("R10", "clear without set", 32'(flags[0]), 32'h0);

    // R6: capture register as ceiling
    tick = 1'b0; wr_cap = 1'b1; wr_data = 16'h0010; cyc();
    run_to(16'h00FF);
    tick = 1'b1; cyc();
    write_ctrl(4'd14, 2'd2, 2'd2);
    tick = 1'b0; clr_flags = 4'hF; cyc();
    run_to(16'h0010);
    chk("R2", "capture ceiling reached", 32'(count), 32'h0010);
    tick = 1'b1; cyc();
    chk("R6", "capture flag with wrap", 32'(flags[3]), 32'h1);
    chk("R6", "wrap flag with capture flag", 32'(flags[0]), 32'h1);
    chk("R6", "count wrapped at capture ceiling", 32'(count), 32'h0);

    // Random phases
    for (int p = 0; p < 10; p++) begin
      logic [3:0] nm;
      nm = modes[$urandom % 5];
      tick = 1'b0; wr_cap = 1'b1; wr_data = 16'($urandom_range(700, 3)); cyc();
      tick = 1'b0; wr_cmp_a = 1'b1; wr_data = 16'($urandom_range(255, 3)); cyc();
      tick = 1'b0; wr_cmp_b = 1'b1; wr_data = 16'($urandom_range(900, 0)); cyc();
      run_to(exp_top(m_mode, m_capa, m_cact[0]));
      tick = 1'b1; cyc();
      write_ctrl(nm, 2'($urandom), 2'($urandom));
      for (int k = 0; k < 2000; k++) begin
        int sel;
        tick = (($urandom % 4) != 0);
        sel = int'($urandom % 300);
        if (sel == 0) begin wr_cmp_a = 1'b1; wr_data = 16'($urandom_range(255, 3)); end
        else if (sel == 1) begin wr_cmp_b = 1'b1; wr_data = 16'($urandom_range(900, 0)); end
        else if (sel == 2) begin wr_cap = 1'b1; wr_data = 16'($urandom_range(700, 3)); end
        if (($urandom % 16) == 0) clr_flags = 4'($urandom);
        cyc();
      end
    end

    summary();
    $finish;
  end

endmodule